// File: doc/BRIEF.md
# Tensor Layout Offset Generator

This block steps through every element of a four-dimensional tensor indexed by batch, channel, row and column, and presents one linear memory offset per accepted cycle. A walk-layout code chooses which storage order sets the visiting sequence and the main offset: batch-channel-row-column (NCHW), batch-row-column-channel (NHWC) or channel-row-column-batch (CHWN). A second layout code chooses the order used for a companion offset of the same element. A copy engine that converts a tensor from one layout to another can therefore read at one offset and write at the other in the same cycle.

The sizes of the four dimensions and both layout codes are sampled when a start pulse arrives while the block is idle. Per-dimension strides, and the distance back to zero for each dimension, are computed once in a setup cycle. After that every step is a single addition to the running offset, with no multiplier in the stepping path. Output follows a valid/ready handshake. A one-cycle done pulse closes each walk.

Top module: `tensor_offset_gen`

## Requirements
- R1: With walk code 0 (NCHW), the column index changes fastest, then row, then channel, then batch, and offset = n*C*H*W + c*H*W + h*W + w.
- R2: With walk code 1 (NHWC), the channel index changes fastest, then column, then row, then batch, and offset = n*H*W*C + h*W*C + w*C + c. For N=2, C=16, H=5, W=4 with a companion NCHW offset, the companion sequence starts 0, 20, …, 300, 1, ends at 639, and coordinate (1,1,0,1) carries companion offset 341.
- R3: With walk code 2 (CHWN), the batch index changes fastest, then column, then row, then channel, and offset = c*H*W*N + h*W*N + w*N + n.
- R4: Every valid cycle presents the coordinates (n, c, h, w) of the current element, and offset_alt holds that same element's offset under the alternate code, using the formulas of R1 to R3.
- R5: The walk advances only on a cycle where valid and ready are both high. While valid is high and ready is low, offset, offset_alt and the coordinates hold their values into the next cycle.
- R6: Exactly N*C*H*W elements are accepted. done is high for one cycle, in the cycle after the last element is accepted, and valid is low whenever done is high.
- R7: If any of the four sizes is zero, valid never rises, and done pulses two cycles after the start pulse.
- R8: A start pulse, or any change of the size and layout inputs, while a walk is under way has no effect on that walk.
- R9: After reset the block is idle with valid and done low. Valid first rises two cycles after the start pulse, with offset 0 and all coordinates 0.
- R10: Layout code 3 behaves exactly as code 0 (NCHW), for both the walk code and the alternate code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a walk when the block is idle |
| dim_n | input | DIM_W | Batch size N |
| dim_c | input | DIM_W | Channel count C |
| dim_h | input | DIM_W | Height H |
| dim_w | input | DIM_W | Width W |
| walk_layout | input | 2 | Layout code for visiting order and main offset (0 NCHW, 1 NHWC, 2 CHWN, 3 as 0) |
| alt_layout | input | 2 | Layout code for the companion offset |
| ready | input | 1 | Consumer accepts the current element |
| valid | output | 1 | An element is presented |
| offset | output | OFF_W | Offset of the element in the walk layout |
| offset_alt | output | OFF_W | Offset of the element in the alternate layout |
| crd_n | output | DIM_W | Batch coordinate |
| crd_c | output | DIM_W | Channel coordinate |
| crd_h | output | DIM_W | Row coordinate |
| crd_w | output | DIM_W | Column coordinate |
| done | output | 1 | One-cycle pulse when a walk ends |

## Verification
The bound checker watches the handshake on every cycle. It checks that presented values hold under back-pressure, that each accepted element is followed by new coordinates or by the end of the walk, that done lasts a single cycle and never coincides with valid, and that each walk opens at the origin with offset zero. Whether the offsets match the layout formulas, whether the visiting order is right, whether exactly N*C*H*W elements are produced, and how zero sizes, layout code 3 and a stray start behave can only be shown by the bench scenarios. Those scenarios compare each presented element with a model built from the formulas.

// File: rtl/tlo_pkg.sv
package tlo_pkg;

   typedef enum logic [1:0] {
      LAY_NCHW = 2'd0,
      LAY_NHWC = 2'd1,
      LAY_CHWN = 2'd2,
      LAY_SPARE = 2'd3
   } layout_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PREP = 2'd1,
      ST_RUN  = 2'd2,
      ST_FIN  = 2'd3
   } gen_state_e;

   localparam int NUM_DIMS = 4;
   localparam int AX_N = 0;
   localparam int AX_C = 1;
   localparam int AX_H = 2;
   localparam int AX_W = 3;

   // Axis that occupies nesting level lvl (0 = fastest) for a layout.
   // The spare code walks like NCHW (R10).
   function automatic logic [1:0] axis_at_level(input layout_e lay, input int lvl);
      logic [1:0] ax;
      ax = 2'(AX_N);
      case (lay)
         LAY_NHWC: begin
            case (lvl)
               0:       ax = 2'(AX_C);
               1:       ax = 2'(AX_W);
               2:       ax = 2'(AX_H);
               default: ax = 2'(AX_N);
            endcase
         end
         LAY_CHWN: begin
            case (lvl)
               0:       ax = 2'(AX_N);
               1:       ax = 2'(AX_W);
               2:       ax = 2'(AX_H);
               default: ax = 2'(AX_C);
            endcase
         end
         default: begin
            case (lvl)
               0:       ax = 2'(AX_W);
               1:       ax = 2'(AX_H);
               2:       ax = 2'(AX_C);
               default: ax = 2'(AX_N);
            endcase
         end
      endcase
      return ax;
   endfunction

endpackage

// File: rtl/tlo_stride_calc.sv
module tlo_stride_calc
   import tlo_pkg::*;
#(
   parameter int DIM_W = 8,
   parameter int OFF_W = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               load,
   input  layout_e                            lay,
   input  logic [NUM_DIMS-1:0][DIM_W-1:0]     size,
   output logic [NUM_DIMS-1:0][OFF_W-1:0]     stride,
   output logic [NUM_DIMS-1:0][OFF_W-1:0]     rewind
);

   logic [NUM_DIMS-1:0][OFF_W-1:0] stride_d;
   logic [NUM_DIMS-1:0][OFF_W-1:0] rewind_d;

   // Stride of each level is the product of the sizes of all faster levels.
   always_comb begin
      logic [OFF_W-1:0] run_prod;
      logic [1:0]       ax;
      run_prod = OFF_W'(1);
      stride_d = '0;
      for (int lvl = 0; lvl < NUM_DIMS; lvl++) begin
         ax           = axis_at_level(lay, lvl);
         stride_d[ax] = run_prod;
         run_prod     = run_prod * OFF_W'(size[ax]);
      end
      for (int a = 0; a < NUM_DIMS; a++) begin
         rewind_d[a] = stride_d[a] * (OFF_W'(size[a]) - OFF_W'(1));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stride <= '0;
         rewind <= '0;
      end else if (load) begin
         stride <= stride_d;
         rewind <= rewind_d;
      end
   end

endmodule

// File: rtl/tlo_counter_nest.sv
module tlo_counter_nest
   import tlo_pkg::*;
#(
   parameter int DIM_W = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clear,
   input  logic                            step,
   input  layout_e                         lay,
   input  logic [NUM_DIMS-1:0][DIM_W-1:0]  size,
   output logic [NUM_DIMS-1:0][DIM_W-1:0]  cnt,
   output logic [NUM_DIMS-1:0]             inc_mask,
   output logic [NUM_DIMS-1:0]             wrap_mask,
   output logic                            all_last
);

   logic [NUM_DIMS-1:0] is_last;

   generate
      for (genvar a = 0; a < NUM_DIMS; a++) begin : g_last
         assign is_last[a] = (cnt[a] == (size[a] - DIM_W'(1)));
      end
   endgenerate

   // Ripple a carry from the fastest level outward in layout order.
   always_comb begin
      logic       carry;
      logic [1:0] ax;
      carry     = 1'b1;
      inc_mask  = '0;
      wrap_mask = '0;
      for (int lvl = 0; lvl < NUM_DIMS; lvl++) begin
         ax = axis_at_level(lay, lvl);
         if (carry) begin
            if (is_last[ax]) wrap_mask[ax] = 1'b1;
            else             inc_mask[ax]  = 1'b1;
         end
         carry = carry & is_last[ax];
      end
      all_last = carry;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (step) begin
         for (int a = 0; a < NUM_DIMS; a++) begin
            if (wrap_mask[a])     cnt[a] <= '0;
            else if (inc_mask[a]) cnt[a] <= cnt[a] + DIM_W'(1);
         end
      end
   end

endmodule

// File: rtl/tlo_offset_accum.sv
module tlo_offset_accum
   import tlo_pkg::*;
#(
   parameter int OFF_W = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clear,
   input  logic                            step,
   input  logic [NUM_DIMS-1:0][OFF_W-1:0]  stride,
   input  logic [NUM_DIMS-1:0][OFF_W-1:0]  rewind,
   input  logic [NUM_DIMS-1:0]             inc_mask,
   input  logic [NUM_DIMS-1:0]             wrap_mask,
   output logic [OFF_W-1:0]                offset
);

   logic [OFF_W-1:0] delta;

   // One axis moves up by its stride; each wrapped axis gives back its span.
   always_comb begin
      delta = '0;
      for (int a = 0; a < NUM_DIMS; a++) begin
         if (inc_mask[a])  delta = delta + stride[a];
         if (wrap_mask[a]) delta = delta - rewind[a];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     offset <= '0;
      else if (clear) offset <= '0;
      else if (step)  offset <= offset + delta;
   end

endmodule

// File: rtl/tensor_offset_gen.sv
module tensor_offset_gen
   import tlo_pkg::*;
#(
   parameter int DIM_W = 8,
   parameter int OFF_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DIM_W-1:0] dim_n,
   input  logic [DIM_W-1:0] dim_c,
   input  logic [DIM_W-1:0] dim_h,
   input  logic [DIM_W-1:0] dim_w,
   input  logic [1:0]       walk_layout,
   input  logic [1:0]       alt_layout,
   input  logic             ready,
   output logic             valid,
   output logic [OFF_W-1:0] offset,
   output logic [OFF_W-1:0] offset_alt,
   output logic [DIM_W-1:0] crd_n,
   output logic [DIM_W-1:0] crd_c,
   output logic [DIM_W-1:0] crd_h,
   output logic [DIM_W-1:0] crd_w,
   output logic             done
);

   localparam int NUM_VIEWS = 2;   // view 0: walk layout, view 1: alternate
   localparam int MAX_ELEMS_W = NUM_DIMS * DIM_W;

   generate
      if (DIM_W < 1) begin : g_chk_dim
         $error("tensor_offset_gen: DIM_W must be at least 1");
      end
      if (OFF_W < MAX_ELEMS_W) begin : g_chk_off
         $error("tensor_offset_gen: OFF_W too narrow for the largest tensor");
      end
   endgenerate

   gen_state_e                      state_q;
   logic [NUM_DIMS-1:0][DIM_W-1:0]  size_q;
   layout_e                         lay_q [NUM_VIEWS];
   logic [NUM_DIMS-1:0][DIM_W-1:0]  cnt;
   logic [NUM_DIMS-1:0]             inc_mask;
   logic [NUM_DIMS-1:0]             wrap_mask;
   logic                            all_last;
   logic [OFF_W-1:0]                view_off [NUM_VIEWS];
   logic                            any_zero;
   logic                            prep;
   logic                            step;
   logic                            finish;

   assign any_zero = (size_q[AX_N] == '0) || (size_q[AX_C] == '0) ||
                     (size_q[AX_H] == '0) || (size_q[AX_W] == '0);
   assign prep     = (state_q == ST_PREP);
   assign step     = (state_q == ST_RUN) && ready && !all_last;
   assign finish   = (state_q == ST_RUN) && ready && all_last;

   // Controller: settings are captured only from idle (R8).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         size_q  <= '0;
         for (int v = 0; v < NUM_VIEWS; v++) lay_q[v] <= LAY_NCHW;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  size_q[AX_N] <= dim_n;
                  size_q[AX_C] <= dim_c;
                  size_q[AX_H] <= dim_h;
                  size_q[AX_W] <= dim_w;
                  lay_q[0]     <= layout_e'(walk_layout);
                  lay_q[1]     <= layout_e'(alt_layout);
                  state_q      <= ST_PREP;
               end
            end
            ST_PREP: state_q <= any_zero ? ST_FIN : ST_RUN;
            ST_RUN:  if (finish) state_q <= ST_FIN;
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   tlo_counter_nest #(.DIM_W(DIM_W)) nest_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (prep),
      .step      (step),
      .lay       (lay_q[0]),
      .size      (size_q),
      .cnt       (cnt),
      .inc_mask  (inc_mask),
      .wrap_mask (wrap_mask),
      .all_last  (all_last)
   );

   generate
      for (genvar v = 0; v < NUM_VIEWS; v++) begin : g_view
         logic [NUM_DIMS-1:0][OFF_W-1:0] stride;
         logic [NUM_DIMS-1:0][OFF_W-1:0] rewind;

         tlo_stride_calc #(.DIM_W(DIM_W), .OFF_W(OFF_W)) stride_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (prep),
            .lay    (lay_q[v]),
            .size   (size_q),
            .stride (stride),
            .rewind (rewind)
         );

         tlo_offset_accum #(.OFF_W(OFF_W)) accum_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (prep),
            .step      (step),
            .stride    (stride),
            .rewind    (rewind),
            .inc_mask  (inc_mask),
            .wrap_mask (wrap_mask),
            .offset    (view_off[v])
         );
      end
   endgenerate

   assign valid      = (state_q == ST_RUN);
   assign done       = (state_q == ST_FIN);
   assign offset     = view_off[0];
   assign offset_alt = view_off[1];
   assign crd_n      = cnt[AX_N];
   assign crd_c      = cnt[AX_C];
   assign crd_h      = cnt[AX_H];
   assign crd_w      = cnt[AX_W];

endmodule

// File: rtl/tlo_checker.sv
module tlo_checker #(
   parameter int DIM_W = 8,
   parameter int OFF_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valid,
   input logic             ready,
   input logic             done,
   input logic [OFF_W-1:0] offset,
   input logic [OFF_W-1:0] offset_alt,
   input logic [DIM_W-1:0] crd_n,
   input logic [DIM_W-1:0] crd_c,
   input logic [DIM_W-1:0] crd_h,
   input logic [DIM_W-1:0] crd_w
);

   // R5: presented element held under back-pressure
   a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable(offset) && $stable(offset_alt) &&
                          $stable({crd_n, crd_c, crd_h, crd_w}));

   // R5: an accepted element is replaced by a new one, or the walk ends
   a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
      valid && ready |=> done ||
                         ({crd_n, crd_c, crd_h, crd_w} != $past({crd_n, crd_c, crd_h, crd_w})));

   // R6: done lasts a single cycle
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: done and valid are never high together
   a_r6_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid && done));

   // R9: a walk opens at the origin with offset zero
   a_r9_origin: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> (offset == '0) && (offset_alt == '0) &&
                       ({crd_n, crd_c, crd_h, crd_w} == '0));

endmodule

bind tensor_offset_gen tlo_checker #(.DIM_W(DIM_W), .OFF_W(OFF_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .valid      (valid),
   .ready      (ready),
   .done       (done),
   .offset     (offset),
   .offset_alt (offset_alt),
   .crd_n      (crd_n),
   .crd_c      (crd_c),
   .crd_h      (crd_h),
   .crd_w      (crd_w)
);

// File: tb/tensor_offset_gen_tb_top.sv
module tensor_offset_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  dim_n = '0, dim_c = '0, dim_h = '0, dim_w = '0;
   logic [1:0]  walk_layout = '0, alt_layout = '0;
   logic        ready = 1'b0;
   logic        valid, done;
   logic [31:0] offset, offset_alt;
   logic [7:0]  crd_n, crd_c, crd_h, crd_w;

   int          checks = 0;
   int          failures = 0;
   bit          finished = 1'b0;
   logic [15:0] lf = 16'hACE1;
   longint      alt_log [0:1023];

   always #2 clk = ~clk;   // 4 ns period

   tensor_offset_gen dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .dim_n(dim_n), .dim_c(dim_c), .dim_h(dim_h), .dim_w(dim_w),
      .walk_layout(walk_layout), .alt_layout(alt_layout), .ready(ready),
      .valid(valid), .offset(offset), .offset_alt(offset_alt),
      .crd_n(crd_n), .crd_c(crd_c), .crd_h(crd_h), .crd_w(crd_w), .done(done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Offset from the layout formulas; code 3 is NCHW (R10).
   function automatic longint exp_off(input int lay, input int n, input int c,
                                      input int h, input int w, input int NN,
                                      input int CC, input int HH, input int WW);
      case (lay)
         1:       return longint'(n)*HH*WW*CC + longint'(h)*WW*CC + longint'(w)*CC + c;
         2:       return longint'(c)*HH*WW*NN + longint'(h)*WW*NN + longint'(w)*NN + n;
         default: return longint'(n)*CC*HH*WW + longint'(c)*HH*WW + longint'(h)*WW + w;
      endcase
   endfunction

   function automatic string lay_req(input int lay);
      case (lay)
         1: return "R2";
         2: return "R3";
         3: return "R10";
         default: return "R1";
      endcase
   endfunction

   // Model of the visiting order: index 0=n 1=c 2=h 3=w.
   task automatic advance_model(inout int ex[4], input int sz[4], input int lay);
      int ord[4];
      case (lay)
         1:       ord = '{1, 3, 2, 0};
         2:       ord = '{0, 3, 2, 1};
         default: ord = '{3, 2, 1, 0};
      endcase
      for (int k = 0; k < 4; k++) begin
         if (ex[ord[k]] + 1 < sz[ord[k]]) begin
            ex[ord[k]]++;
            return;
         end
         ex[ord[k]] = 0;
      end
   endtask

   task automatic run_case(input int NN, input int CC, input int HH, input int WW,
                           input int lw, input int la, input bit bp, input bit poke);
      int     total = NN*CC*HH*WW;
      int     sz[4];
      int     ex[4];
      int     acc = 0;
      int     cyc = 0;
      int     first_valid = -1;
      bit     got_done = 1'b0;
      bit     hold = 1'b0;
      longint prev_off = 0;
      sz = '{NN, CC, HH, WW};
      ex = '{0, 0, 0, 0};
      @(negedge clk);
      dim_n = 8'(NN); dim_c = 8'(CC); dim_h = 8'(HH); dim_w = 8'(WW);
      walk_layout = 2'(lw); alt_layout = 2'(la);
      start = 1'b1; ready = 1'b0;
      @(negedge clk);
      start = 1'b0;
      check(!valid, "R9", "valid one cycle after start", valid, 0);
      while (!got_done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
         if (done) begin
            got_done = 1'b1;
            check(!valid, "R6", "valid during done", valid, 0);
         end else begin
            if (valid) begin
               if (first_valid < 0) begin
                  first_valid = cyc;
                  check(cyc == 1, "R9", "first valid cycle", cyc, 1);
                  check(offset == 0, "R9", "first offset", offset, 0);
               end
               if (hold) check(offset == prev_off, "R5", "held offset", offset, prev_off);
               check(offset == exp_off(lw, ex[0], ex[1], ex[2], ex[3], NN, CC, HH, WW),
                     lay_req(lw), "walk offset", offset,
                     exp_off(lw, ex[0], ex[1], ex[2], ex[3], NN, CC, HH, WW));
               check(offset_alt == exp_off(la, ex[0], ex[1], ex[2], ex[3], NN, CC, HH, WW),
                     "R4", "alt offset", offset_alt,
                     exp_off(la, ex[0], ex[1], ex[2], ex[3], NN, CC, HH, WW));
               check({crd_n, crd_c, crd_h, crd_w} ==
                     {8'(ex[0]), 8'(ex[1]), 8'(ex[2]), 8'(ex[3])}, "R4", "coordinates",
                     {crd_n, crd_c, crd_h, crd_w},
                     {8'(ex[0]), 8'(ex[1]), 8'(ex[2]), 8'(ex[3])});
               prev_off = offset;
            end
            ready = bp ? (lf[0] | lf[3]) : 1'b1;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            hold = valid && !ready;
            if (valid && ready) begin
               if (acc < 1024) alt_log[acc] = offset_alt;
               acc++;
               advance_model(ex, sz, lw);
            end
            if (poke) begin
               // R8: stray start and new settings in mid-walk
               start = (acc == 3);
               if (acc == 3) begin
                  dim_n = 8'(NN + 1); dim_c = 8'(CC + 2); walk_layout = 2'((lw + 1) % 3);
               end
            end
         end
      end
      start = 1'b0;
      ready = 1'b0;
      check(got_done, "R6", "done seen", got_done, 1);
      check(acc == total, poke ? "R8" : "R6", "accepted count", acc, total);
      if (total == 0) begin
         check(first_valid < 0, "R7", "valid with zero size", first_valid, -1);
         check(cyc == 1, "R7", "done cycle with zero size", cyc, 1);
      end
      @(negedge clk);
      check(!done, "R6", "done width", done, 0);
   endtask

   task automatic test_reset();
      check(!valid, "R9", "valid in reset idle", valid, 0);
      check(!done, "R9", "done in reset idle", done, 0);
   endtask

   task automatic test_nhwc_example();
      run_case(2, 16, 5, 4, 1, 0, 1'b1, 1'b0);
      check(alt_log[1] == 20, "R2", "second NCHW index", alt_log[1], 20);
      check(alt_log[15] == 300, "R2", "16th NCHW index", alt_log[15], 300);
      check(alt_log[16] == 1, "R2", "17th NCHW index", alt_log[16], 1);
      check(alt_log[337] == 341, "R2", "coordinate (1,1,0,1)", alt_log[337], 341);
      check(alt_log[639] == 639, "R2", "final NCHW index", alt_log[639], 639);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      test_reset();
      run_case(2, 3, 2, 3, 0, 1, 1'b0, 1'b0);   // R1 walk, NHWC companion
      test_nhwc_example();                       // R2 with back-pressure
      run_case(3, 2, 3, 2, 2, 1, 1'b1, 1'b0);   // R3 walk
      run_case(2, 0, 3, 3, 1, 2, 1'b0, 1'b0);   // R7 zero channels
      run_case(3, 2, 2, 2, 3, 2, 1'b1, 1'b1);   // R10 code 3, R8 stray start
      run_case(2, 3, 2, 2, 2, 3, 1'b0, 1'b0);   // R10 as alternate code
      run_case(1, 1, 1, 1, 1, 2, 1'b1, 1'b0);   // single element
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #600000;
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule